// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with Per-Set LRU

This block is a small read-only cache that sits between a word-oriented requester and a slower next-level memory. It holds four sets of two ways. Each way stores one 32-bit word along with its tag and a valid flag. A byte address is split into a byte offset, a set index and a tag. Both ways of the selected set are compared at the same time. On a hit, the word is returned combinationally in the same cycle as the request.

On a miss, the block drops its ready output to stall the requester. It then asks the next-level memory for the word-aligned address and waits for the refill data. The word is written into the chosen way. The request still being held is then answered as a hit in the following cycle.

Each set keeps one use bit that names its least recently used way. A set with an empty way fills the empty way first, taking way 0 before way 1. Otherwise the way named by the use bit is evicted.

Top module: `twoway_lru_cache`

## Requirements
- R1: The address is split as byte offset = bits [1:0], set index = bits [3:2] and tag = bits [31:4]. The offset bits never affect hit, data or the refill address.
- R2: While idle, a request whose set holds a valid way with an equal tag returns that way's word on rsp_data in the same cycle, with rsp_hit = 1 and req_ready = 1.
- R3: A request that misses drives req_ready = 0 and rsp_hit = 0. From the next cycle until the clock edge on which mem_valid is sampled high, mem_req = 1, req_ready = 0 and mem_addr = {tag, set, 2'b00}, held stable.
- R4: In the cycle after the edge that takes mem_valid, the held request is answered with rsp_hit = 1 and rsp_data equal to the refill word.
- R5: A refill goes to way 0 if way 0 is invalid, else to way 1 if way 1 is invalid, else to the way named by the set's use bit.
- R6: Every hit and every refill sets the set's use bit to the way other than the one just accessed.
- R7: Byte addresses 0x04 and 0x24 both map to set 1 and stay resident together. After both are loaded, neither misses.
- R8: Loading 0x04, then 0x24, then 0x54 evicts 0x04 and leaves 0x24 and 0x54 resident.
- R9: Reset clears every valid bit and use bit. After reset the block is idle with mem_req = 0 and rsp_hit = 0, and the first access to any address misses.
- R10: A refill or hit in one set never changes the contents or use bit of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester presents an address |
| req_addr | input | 32 | Byte address of the requested word |
| req_ready | output | 1 | Low while a miss is being serviced |
| rsp_hit | output | 1 | rsp_data holds the requested word this cycle |
| rsp_data | output | 32 | Word returned to the requester |
| mem_req | output | 1 | Refill request to next-level memory |
| mem_addr | output | 32 | Word-aligned refill address |
| mem_valid | input | 1 | Next-level memory returns refill data |
| mem_data | input | 32 | Refill word |

## Verification
The assertions take for granted that a stalled requester keeps req_valid high and req_addr unchanged until it sees rsp_hit. They also assume the next-level memory raises mem_valid only while mem_req is high. The delivery-after-refill property depends on these conditions. The bench drives addresses only on falling edges. It holds each missing address until the hit comes back, and it answers refills after a latency of zero to two cycles, which stays inside those limits. A reference model of tags, valid bits and use bits in the bench predicts hit or miss for every access. The sweep spans all sets, three competing tags per set, high tag bits and all byte offsets.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic {
    CS_LOOKUP = 1'b0,
    CS_REFILL = 1'b1
  } cache_state_t;

  // Replacement choice: empty way 0, then empty way 1, then the LRU way.
  function automatic logic pick_victim(input logic valid0, input logic valid1,
                                       input logic lru_way);
    if (!valid0)      return 1'b0;
    else if (!valid1) return 1'b1;
    else              return lru_way;
  endfunction

  // Way that becomes least recently used after an access to way w.
  function automatic logic next_lru(input logic accessed_way);
    return ~accessed_way;
  endfunction

endpackage

// File: rtl/cache_way_array.sv
module cache_way_array #(
  parameter int SETS   = 4,
  parameter int SET_W  = 2,
  parameter int TAG_W  = 28,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_valid,
  output logic              rd_hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_set] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data;
    end
  end

  always_comb begin
    rd_valid = valid_q[rd_set];
    rd_hit   = valid_q[rd_set] && (tag_q[rd_set] == rd_tag);
    rd_data  = data_q[rd_set];
  end

endmodule

// File: rtl/cache_lru_bits.sv
module cache_lru_bits #(
  parameter int SETS  = 4,
  parameter int SET_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic [SET_W-1:0] rd_set,
  output logic             lru_way,
  output logic [SETS-1:0]  use_vec
);

  import cache_pkg::*;

  logic [SETS-1:0] use_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      use_q <= '0;
    end else if (touch) begin
      use_q[touch_set] <= next_lru(touch_way);
    end
  end

  assign lru_way = use_q[rd_set];
  assign use_vec = use_q;

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic lookup_hit,
  input  logic mem_valid,
  output logic in_lookup,
  output logic start_miss,
  output logic fill_done
);

  import cache_pkg::*;

  cache_state_t state_q, state_d;

  always_comb begin
    in_lookup  = (state_q == CS_LOOKUP);
    start_miss = in_lookup && req_valid && !lookup_hit;
    fill_done  = (state_q == CS_REFILL) && mem_valid;
    state_d    = state_q;
    if (start_miss) state_d = CS_REFILL;
    else if (fill_done) state_d = CS_LOOKUP;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= CS_LOOKUP;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/twoway_lru_cache.sv
module twoway_lru_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_data
);

  import cache_pkg::*;

  localparam int SET_W    = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W    = ADDR_W - SET_W - OFF_W;
  localparam int NUM_WAYS = 2;

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  logic [SET_W-1:0]  look_set;
  logic [TAG_W-1:0]  look_tag;
  logic [SET_W-1:0]  miss_set_q;
  logic [TAG_W-1:0]  miss_tag_q;
  logic              victim_q;

  logic [NUM_WAYS-1:0] way_hit;
  logic [NUM_WAYS-1:0] way_valid;
  logic [NUM_WAYS-1:0] way_wr;
  logic [DATA_W-1:0]   way_data [NUM_WAYS];

  logic in_lookup, start_miss, fill_done;
  logic lookup_hit, hit_way, lru_way, victim_way;

  logic             lru_touch;
  logic [SET_W-1:0] lru_touch_set;
  logic             lru_touch_way;
  logic [SETS-1:0]  use_vec;

  assign look_set   = set_of(req_addr);
  assign look_tag   = tag_of(req_addr);
  assign lookup_hit = |way_hit;
  assign hit_way    = way_hit[1];
  assign victim_way = pick_victim(way_valid[0], way_valid[1], lru_way);

  generate
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
      assign way_wr[w] = fill_done && (victim_q == w[0]);
      cache_way_array #(
        .SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
      ) u_way (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (look_set),
        .rd_tag  (look_tag),
        .rd_valid(way_valid[w]),
        .rd_hit  (way_hit[w]),
        .rd_data (way_data[w]),
        .wr_en   (way_wr[w]),
        .wr_set  (miss_set_q),
        .wr_tag  (miss_tag_q),
        .wr_data (mem_data)
      );
    end
  endgenerate

  cache_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .lookup_hit(lookup_hit),
    .mem_valid (mem_valid),
    .in_lookup (in_lookup),
    .start_miss(start_miss),
    .fill_done (fill_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      miss_set_q <= '0;
      miss_tag_q <= '0;
      victim_q   <= 1'b0;
    end else if (start_miss) begin
      miss_set_q <= look_set;
      miss_tag_q <= look_tag;
      victim_q   <= victim_way;
    end
  end

  assign rsp_hit = in_lookup && req_valid && lookup_hit;

  always_comb begin
    lru_touch     = rsp_hit || fill_done;
    lru_touch_set = fill_done ? miss_set_q : look_set;
    lru_touch_way = fill_done ? victim_q   : hit_way;
  end

  cache_lru_bits #(.SETS(SETS), .SET_W(SET_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .touch    (lru_touch),
    .touch_set(lru_touch_set),
    .touch_way(lru_touch_way),
    .rd_set   (look_set),
    .lru_way  (lru_way),
    .use_vec  (use_vec)
  );

  assign req_ready = in_lookup && (!req_valid || lookup_hit);
  assign rsp_data  = way_data[hit_way];
  assign mem_req   = !in_lookup;
  assign mem_addr  = {miss_tag_q, miss_set_q, {OFF_W{1'b0}}};

endmodule

// File: rtl/cache_checker.sv
module cache_checker #(
  parameter int ADDR_W = 32,
  parameter int SETS   = 4,
  parameter int SET_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_hit,
  input logic              mem_req,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        way_hit,
  input logic              lru_touch,
  input logic [SET_W-1:0]  lru_touch_set,
  input logic              lru_touch_way,
  input logic [SETS-1:0]   use_vec
);

  // R3: the requester is stalled for the whole refill
  assert_stall_in_refill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R3: refill address holds until the data arrives
  assert_mem_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  // R4: a completed refill is answered as a hit on the next cycle
  assert_hit_after_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> rsp_hit);

  // R2: a hit never coincides with a stall
  assert_hit_is_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> req_ready);

  // R5: the same word never sits in both ways of a set
  assert_single_way_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_hit));

  // R6: after an access the use bit names the other way
  assert_use_bit_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lru_touch |=> (use_vec[$past(lru_touch_set)] == ~$past(lru_touch_way)));

  // R9: no refill is pending right after reset
  assert_idle_after_reset_R9: assert property (@(posedge clk)
    !rst_n |=> !mem_req);

endmodule

bind twoway_lru_cache cache_checker #(
  .ADDR_W(ADDR_W), .SETS(SETS), .SET_W(SET_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_hit      (rsp_hit),
  .mem_req      (mem_req),
  .mem_valid    (mem_valid),
  .mem_addr     (mem_addr),
  .way_hit      (way_hit),
  .lru_touch    (lru_touch),
  .lru_touch_set(lru_touch_set),
  .lru_touch_way(lru_touch_way),
  .use_vec      (use_vec)
);

// File: tb/sim_twoway_lru_cache.sv
`timescale 1ns/1ps
module sim_twoway_lru_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_hit, mem_req;
  logic [31:0] rsp_data, mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  twoway_lru_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data)
  );

  // reference model
  bit       m_valid [4][2];
  bit [27:0] m_tag  [4][2];
  bit       m_lru   [4];

  function automatic logic [31:0] word_of(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit model_hit(input logic [31:0] a);
    int s;
    s = a[3:2];
    return (m_valid[s][0] && m_tag[s][0] == a[31:4]) ||
           (m_valid[s][1] && m_tag[s][1] == a[31:4]);
  endfunction

  task automatic model_access(input logic [31:0] a);
    int s; bit w;
    s = a[3:2];
    if (m_valid[s][0] && m_tag[s][0] == a[31:4]) w = 0;
    else if (m_valid[s][1] && m_tag[s][1] == a[31:4]) w = 1;
    else begin
      if (!m_valid[s][0]) w = 0;
      else if (!m_valid[s][1]) w = 1;
      else w = m_lru[s];
      m_valid[s][w] = 1;
      m_tag[s][w]   = a[31:4];
    end
    m_lru[s] = ~w;
  endtask

  // One access; inputs change on falling edges, outputs sampled 1 ns later.
  task automatic access(input logic [31:0] a, input int lat, input string req);
    bit exp_hit;
    exp_hit = model_hit(a);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    #1;
    if (exp_hit) begin
      check(rsp_hit === 1'b1, {req, " hit"}, {31'd0, rsp_hit}, 32'd1);
      check(req_ready === 1'b1, {req, " R2 ready"}, {31'd0, req_ready}, 32'd1);
      check(rsp_data === word_of(a), {req, " R2 data"}, rsp_data, word_of(a));
    end else begin
      check(rsp_hit === 1'b0, {req, " miss"}, {31'd0, rsp_hit}, 32'd0);
      check(req_ready === 1'b0, {req, " R3 stall"}, {31'd0, req_ready}, 32'd0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk); #1;
        check(mem_req === 1'b1 && req_ready === 1'b0, {req, " R3 wait"},
              {31'd0, mem_req}, 32'd1);
      end
      @(negedge clk);
      #1;
      check(mem_req === 1'b1, {req, " R3 mem_req"}, {31'd0, mem_req}, 32'd1);
      check(mem_addr === {a[31:2], 2'b00}, {req, " R1 R3 mem_addr"}, mem_addr,
            {a[31:2], 2'b00});
      mem_valid = 1'b1;
      mem_data  = word_of(a);
      @(negedge clk);
      mem_valid = 1'b0;
      mem_data  = '0;
      #1;
      check(rsp_hit === 1'b1, {req, " R4 hit after refill"}, {31'd0, rsp_hit}, 32'd1);
      check(rsp_data === word_of(a), {req, " R4 data"}, rsp_data, word_of(a));
      check(mem_req === 1'b0, {req, " R4 refill ended"}, {31'd0, mem_req}, 32'd0);
    end
    model_access(a);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r;
    logic [31:0] a;
    logic [27:0] tags [3];
    for (int s = 0; s < 4; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 2; w++) begin m_valid[s][w] = 0; m_tag[s][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset state
    check(mem_req === 1'b0, "R9 mem_req after reset", {31'd0, mem_req}, 32'd0);
    check(rsp_hit === 1'b0, "R9 rsp_hit after reset", {31'd0, rsp_hit}, 32'd0);
    check(req_ready === 1'b1, "R9 ready when idle", {31'd0, req_ready}, 32'd1);

    // R7: 0x04 and 0x24 share set 1 without conflict
    access(32'h04, 0, "R9 first miss");
    access(32'h24, 1, "R7 second way");
    access(32'h04, 0, "R7 reuse 0x04");
    access(32'h24, 0, "R7 reuse 0x24");
    check(model_hit(32'h04) && model_hit(32'h24), "R7 model", 32'd1, 32'd1);
    // R1: offset bits ignored
    access(32'h27, 0, "R1 offset 3");
    access(32'h05, 0, "R1 offset 1");
    idle();

    // R8: 0x04, 0x24, 0x54 from a clean reset
    @(negedge clk); rst_n = 1'b0;
    for (int s = 0; s < 4; s++) begin
      m_lru[s] = 0; m_valid[s][0] = 0; m_valid[s][1] = 0;
    end
    @(negedge clk); rst_n = 1'b1;
    access(32'h04, 2, "R9 miss after reset");
    access(32'h24, 0, "R5 fill way1");
    access(32'h54, 1, "R8 evict");
    access(32'h24, 0, "R8 0x24 resident");
    access(32'h54, 0, "R8 0x54 resident");
    check(!model_hit(32'h04), "R8 model evicts 0x04", 32'd0, 32'd0);
    access(32'h04, 0, "R8 0x04 misses");
    // R10: other sets still empty
    access(32'h00, 1, "R10 set0 empty");
    access(32'h08, 0, "R10 set2 empty");
    access(32'h24, 0, "R10 set1 unchanged");
    idle();

    // Sweep: all sets, three competing tags each, all offsets (R5 R6 R10)
    tags[0] = 28'h0000000; tags[1] = 28'hFFFFFFF; tags[2] = 28'h8000003;
    r = 32'h1234_5678;
    for (int n = 0; n < 400; n++) begin
      r = r * 1103515245 + 12345;
      a = {tags[(r >>> 16) % 3 < 0 ? 0 : ((r >> 16) & 32'h7FFF) % 3],
           r[21:20], r[23:22]};
      access(a, (r >> 24) & 3 % 3, "R5 R6 R10 sweep");
      if (r[27]) idle();
    end
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule